// File: doc/BRIEF.md
# Clocked Synchronous Serial Shifter

This block is the clock-synchronous half of a serial communications unit. It moves 8-bit words over a data-out line, a data-in line and a serial clock. Each word is bare: no start, stop or parity bits. The data-out line changes on falling edges of the serial clock, and the data-in line is sampled on rising edges. Transmit and receive run in lock step, so every word sent also captures one word from the input line.

Edge events come from one of two sources. In internal mode, a strobe from a rate generator outside the block delivers two events per bit. A one-bit phase register turns these into alternating falling and rising edges, and the block drives the serial clock itself. In external mode, a bit-rate clock from outside is synchronised, and its falling and rising edges play the same roles. The clock output then stays high.

The host offers bytes through a valid/ready handshake. If a byte is waiting when a word ends and transmit is enabled, the next word starts with no gap. Received bytes go to a holding register with a full flag and an overrun flag.

Top module: `sss_sync_shifter`

## Requirements
- R1: After reset, `txd`, `sclk_out` are 1; `rx_full`, `rx_ovr`, `tx_end`, `tx_irq` are 0 and `rx_data` is 0.
- R2: A word sends `tx_byte` least significant bit first. Bit k appears on `txd` after the k-th launch event, and exactly 8 bits go out.
- R3: After a word is loaded, the first event is a launch (falling edge), and launch and capture events then alternate. In internal mode each `tick` pulse seen while a word is in progress is one event.
- R4: In internal mode `sclk_out` goes to 0 on each launch and to 1 on each capture. Whenever no word is in progress, `sclk_out` is 1. In external mode it stays 1.
- R5: In external mode (`ext_mode`=1), `tick` is ignored. A falling edge of `ext_sclk` counts as a launch, and a rising edge as a capture. Either counts only when it is the expected next event, and it acts on the third rising edge of `clk` after the change on the pin.
- R6: At each capture the value of `rxd` enters the receive shift register at bit 7 while the register shifts right. After 8 captures, bit k of the received byte holds the k-th sampled value.
- R7: At the end of a word the received byte goes to `rx_data` and `rx_full` is set. If `rx_full` is still set, `rx_ovr` is set instead and `rx_data` keeps its value. A pulse on `rx_read` clears both flags, and it takes effect before a delivery in the same cycle.
- R8: On the capture of the eighth bit, `txd` returns to 1. If no next word is loaded in that cycle, `tx_end` is set. `tx_irq` equals `tx_end` AND `tei_en`. Loading a word clears `tx_end`.
- R9: `tx_ready` is high exactly when `tx_en` and `tx_valid` are high and either no word is in progress or the current cycle holds the final capture. A byte waiting at the end of a word therefore starts the next word with no idle event between them.
- R10: With `tx_en` low, no word starts whatever `tx_valid` and `tick` do. Events that arrive while no word is in progress change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 1: edges come from `ext_sclk`; 0: edges come from `tick` |
| tick | input | 1 | Edge-event strobe, two per bit (internal mode) |
| ext_sclk | input | 1 | External bit-rate serial clock |
| rxd | input | 1 | Serial data in |
| tx_byte | input | 8 | Byte offered for transmission |
| tx_valid | input | 1 | `tx_byte` is valid |
| tx_en | input | 1 | Transmit enable |
| tei_en | input | 1 | Transmit-end interrupt enable |
| rx_read | input | 1 | Host has read `rx_data`; clears full and overrun |
| tx_ready | output | 1 | `tx_byte` is accepted this cycle |
| txd | output | 1 | Serial data out |
| sclk_out | output | 1 | Serial clock out |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | `rx_data` holds an unread byte |
| rx_ovr | output | 1 | A byte was lost because `rx_data` was unread |
| tx_end | output | 1 | Transmitter finished and idle |
| tx_irq | output | 1 | Transmit-end interrupt |

## Verification
The assertions assume that `ext_mode` changes only while no word is in progress. They also assume that `ext_sclk` stays high or low for at least two `clk` cycles, so that the synchroniser sees every level. The stimulus switches mode only after the reference model reports the shifter idle. It runs the external clock with a half period of five cycles. `tick` and `rxd` are driven half a cycle away from the active edge, and `rxd` is a pseudo-random sequence. The `tick` spacing varies from every cycle to every third cycle, which exercises both back-to-back and sparse events.

// File: rtl/sss_pkg.sv
package sss_pkg;
  // What the phase register expects next while a word is in progress.
  typedef enum logic {
    PH_CAPTURE_NEXT = 1'b0,
    PH_LAUNCH_NEXT  = 1'b1
  } phase_e;

  typedef struct packed {
    logic launch;   // falling serial edge: drive next tx bit
    logic capture;  // rising serial edge: sample rx bit
  } shift_ev_t;
endpackage

// File: rtl/sss_edge_sync.sv
module sss_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[LAST-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[LAST-1] & ~sh_q[LAST];
  assign fall = ~sh_q[LAST-1] & sh_q[LAST];
endmodule

// File: rtl/sss_phase.sv
module sss_phase
  import sss_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ext_mode,
  input  logic      tick,
  input  logic      ext_rise,
  input  logic      ext_fall,
  input  logic      busy,
  input  logic      start,
  output shift_ev_t ev,
  output logic      sclk_out
);
  phase_e ph_q, ph_d;
  logic   sclk_q, sclk_d;
  logic   launch_src, capture_src;

  always_comb begin
    launch_src  = ext_mode ? ext_fall : tick;
    capture_src = ext_mode ? ext_rise : tick;
    ev.launch   = busy & (ph_q == PH_LAUNCH_NEXT)  & launch_src;
    ev.capture  = busy & (ph_q == PH_CAPTURE_NEXT) & capture_src;

    ph_d = ph_q;
    if (start)           ph_d = PH_LAUNCH_NEXT;
    else if (ev.launch)  ph_d = PH_CAPTURE_NEXT;
    else if (ev.capture) ph_d = PH_LAUNCH_NEXT;

    sclk_d = sclk_q;
    if (!busy)                       sclk_d = 1'b1;
    else if (ev.launch && !ext_mode) sclk_d = 1'b0;
    else if (ev.capture)             sclk_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_LAUNCH_NEXT;
      sclk_q <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_out = sclk_q;
endmodule

// File: rtl/sss_shift.sv
module sss_shift
  import sss_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  shift_ev_t         ev,
  input  logic              load,
  input  logic [WORD_W-1:0] tx_byte,
  input  logic              rxd,
  output logic              busy,
  output logic              txd,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [WORD_W-1:0] tsr_q, tsr_d, rsr_q, rsr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d, txd_q, txd_d;

  always_comb begin
    done    = ev.capture & (cnt_q == CNT_ONE);
    rx_word = {rxd, rsr_q[WORD_W-1:1]};

    tsr_d  = tsr_q;
    rsr_d  = rsr_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    txd_d  = txd_q;

    if (ev.launch) begin
      txd_d = tsr_q[0];
      tsr_d = tsr_q >> 1;
    end
    if (ev.capture) begin
      rsr_d = rx_word;
      cnt_d = cnt_q - CNT_ONE;
      if (done) begin
        busy_d = 1'b0;
        txd_d  = 1'b1;
      end
    end
    if (load) begin
      tsr_d  = tx_byte;
      cnt_d  = CNT_FULL;
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsr_q  <= '0;
      rsr_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
    end else begin
      tsr_q  <= tsr_d;
      rsr_q  <= rsr_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      txd_q  <= txd_d;
    end
  end

  assign busy = busy_q;
  assign txd  = txd_q;
endmodule

// File: rtl/sss_rx_hold.sv
module sss_rx_hold #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [WORD_W-1:0] word,
  input  logic              rd,
  output logic [WORD_W-1:0] data,
  output logic              full,
  output logic              ovr
);
  logic [WORD_W-1:0] data_q, data_d;
  logic              full_q, full_d, ovr_q, ovr_d;

  always_comb begin
    data_d = data_q;
    full_d = full_q & ~rd;
    ovr_d  = ovr_q & ~rd;
    if (done) begin
      if (full_d) begin
        ovr_d = 1'b1;
      end else begin
        data_d = word;
        full_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
    end
  end

  assign data = data_q;
  assign full = full_q;
  assign ovr  = ovr_q;
endmodule

// File: rtl/sss_sync_shifter.sv
module sss_sync_shifter
  import sss_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic              tick,
  input  logic              ext_sclk,
  input  logic              rxd,
  input  logic [WORD_W-1:0] tx_byte,
  input  logic              tx_valid,
  input  logic              tx_en,
  input  logic              tei_en,
  input  logic              rx_read,
  output logic              tx_ready,
  output logic              txd,
  output logic              sclk_out,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_ovr,
  output logic              tx_end,
  output logic              tx_irq
);
  shift_ev_t         ev;
  logic              ext_rise, ext_fall;
  logic              busy, word_done, load, start;
  logic [WORD_W-1:0] rx_word;
  logic              tend_q, tend_d;

  sss_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_sclk), .rise(ext_rise), .fall(ext_fall)
  );

  sss_phase i_phase (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .tick(tick),
    .ext_rise(ext_rise), .ext_fall(ext_fall), .busy(busy), .start(start),
    .ev(ev), .sclk_out(sclk_out)
  );

  sss_shift #(.WORD_W(WORD_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .ev(ev), .load(load), .tx_byte(tx_byte),
    .rxd(rxd), .busy(busy), .txd(txd), .done(word_done), .rx_word(rx_word)
  );

  sss_rx_hold #(.WORD_W(WORD_W)) i_rx (
    .clk(clk), .rst_n(rst_n), .done(word_done), .word(rx_word), .rd(rx_read),
    .data(rx_data), .full(rx_full), .ovr(rx_ovr)
  );

  always_comb begin
    load   = tx_en & tx_valid & (~busy | word_done);
    start  = load;
    tend_d = tend_q;
    if (load)           tend_d = 1'b0;
    else if (word_done) tend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tend_q <= 1'b0;
    else        tend_q <= tend_d;
  end

  assign tx_ready = load;
  assign tx_end   = tend_q;
  assign tx_irq   = tend_q & tei_en;
endmodule

// File: rtl/sss_sync_shifter_chk.sv
module sss_sync_shifter_chk (
  input logic clk,
  input logic rst_n,
  input logic ext_mode,
  input logic tx_en,
  input logic busy,
  input logic word_done,
  input logic txd,
  input logic sclk_out,
  input logic rx_full,
  input logic rx_ovr,
  input logic tx_end
);
  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_out); // R4

  AST_EXT_SCLK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && $past(ext_mode) && $past(sclk_out)) |-> sclk_out); // R5

  AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R8

  AST_TEND_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |-> !busy); // R8

  AST_FULL_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> rx_full); // R7

  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr |-> rx_full); // R7

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_en)); // R10
endmodule

bind sss_sync_shifter sss_sync_shifter_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .tx_en(tx_en),
  .busy(busy), .word_done(word_done), .txd(txd), .sclk_out(sclk_out),
  .rx_full(rx_full), .rx_ovr(rx_ovr), .tx_end(tx_end)
);

// File: tb/test_sss_sync_shifter.sv
`timescale 1ns/1ps
module test_sss_sync_shifter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_mode = 1'b0, tick = 1'b0, ext_sclk = 1'b1, rxd = 1'b1;
  logic [7:0] tx_byte = 8'h00;
  logic       tx_valid = 1'b0, tx_en = 1'b0, tei_en = 1'b0, rx_read = 1'b0;
  logic       tx_ready, txd, sclk_out, rx_full, rx_ovr, tx_end, tx_irq;
  logic [7:0] rx_data;

  int vectors = 0, errors = 0;
  bit checking = 1'b0, finished = 1'b0;
  int tick_div = 0;      // 0: no ticks
  int ext_half = 0;      // 0: external clock parked high
  int lfsr = 32'h1ace;

  always #2 clk = ~clk;  // 250 MHz

  sss_sync_shifter i_sss_sync_shifter (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .tick(tick), .ext_sclk(ext_sclk),
    .rxd(rxd), .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_en(tx_en), .tei_en(tei_en),
    .rx_read(rx_read), .tx_ready(tx_ready), .txd(txd), .sclk_out(sclk_out),
    .rx_data(rx_data), .rx_full(rx_full), .rx_ovr(rx_ovr), .tx_end(tx_end), .tx_irq(tx_irq)
  );

  // ---------------- behavioural reference ----------------
  logic       e_txd = 1'b1, e_sclk = 1'b1, e_full = 1'b0, e_ovr = 1'b0, e_tend = 1'b0;
  logic [7:0] e_data = 8'h00, m_word = 8'h00;
  bit         m_busy = 1'b0, m_want_cap = 1'b0;
  int         m_sent = 0, m_got = 0;
  bit         m_bits[$];
  bit         h1 = 1'b1, h2 = 1'b1, h3 = 1'b1;  // ext_sclk seen at the last three edges

  function automatic bit model_event();
    bit r, f;
    r = h2 & !h3;
    f = !h2 & h3;
    if (ext_mode) return m_want_cap ? r : f;
    return tick;
  endfunction

  function automatic bit model_ready();
    bit fin;
    fin = m_busy && m_want_cap && model_event() && (m_got == 7);
    return tx_en && tx_valid && (!m_busy || fin);
  endfunction

  always @(posedge clk) begin
    bit ev, rdy, fin;
    logic [7:0] b;
    if (!rst_n) begin
      e_txd = 1; e_sclk = 1; e_full = 0; e_ovr = 0; e_tend = 0; e_data = 0;
      m_busy = 0; m_want_cap = 0; h1 = 1; h2 = 1; h3 = 1;
    end else begin
      ev  = model_event();
      rdy = model_ready();
      fin = 0;
      if (rx_read) begin e_full = 0; e_ovr = 0; end
      if (m_busy && ev) begin
        if (!m_want_cap) begin
          e_txd = m_word[m_sent];
          m_sent++;
          if (!ext_mode) e_sclk = 0;
          m_want_cap = 1;
        end else begin
          m_bits.push_back(rxd);
          m_got++;
          e_sclk = 1;
          m_want_cap = 0;
          if (m_got == 8) begin
            fin = 1; m_busy = 0; e_txd = 1;
            for (int k = 0; k < 8; k++) b[k] = m_bits[k];
            m_bits.delete();
            if (e_full) e_ovr = 1;
            else begin e_data = b; e_full = 1; end
          end
        end
      end
      if (rdy) begin
        m_word = tx_byte; m_busy = 1; m_want_cap = 0; m_sent = 0; m_got = 0; e_tend = 0;
      end else if (fin) e_tend = 1;
      h3 = h2; h2 = h1; h1 = ext_sclk;
    end
  end

  task automatic cmp(input string req, input string name, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", req, name, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (checking) begin
      cmp("R2/R8", "txd", txd, e_txd);
      cmp("R4", "sclk_out", sclk_out, e_sclk);
      cmp("R6", "rx_data", rx_data, e_data);
      cmp("R7", "rx_full", rx_full, e_full);
      cmp("R7", "rx_ovr", rx_ovr, e_ovr);
      cmp("R8", "tx_end", tx_end, e_tend);
      cmp("R8", "tx_irq", tx_irq, e_tend & tei_en);
      cmp("R9/R10", "tx_ready", tx_ready, model_ready());
    end
  end

  // ---------------- stimulus generators ----------------
  initial begin
    int cyc = 0, ecnt = 0;
    forever begin
      @(negedge clk);
      cyc++;
      tick = (tick_div != 0) && (cyc % tick_div == 0);
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h8000_0057 : 0);
      rxd = lfsr[0];
      if (ext_half == 0) begin ext_sclk = 1; ecnt = 0; end
      else begin
        ecnt++;
        if (ecnt >= ext_half) begin ecnt = 0; ext_sclk = ~ext_sclk; end
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    tx_byte = b; tx_valid = 1;
    #1;
    while (!tx_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((m_busy || tx_valid) && n < 5000) begin @(negedge clk); n++; end
    cycles(4);
  endtask

  task automatic read_rx();
    @(negedge clk); rx_read = 1;
    @(negedge clk); rx_read = 0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired at %0t: actual running expected finished", $time);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    end
    $finish;
  end

  initial begin
    cycles(3);
    checking = 1;              // R1: reset values compared while held in reset
    cycles(2);
    rst_n = 1;
    // R10: ticks while idle and valid without enable start nothing
    tick_div = 1; tx_byte = 8'h3C; tx_valid = 1;
    cycles(40);
    tx_valid = 0;
    // R2 R3 R6: one word, tick every cycle
    tx_en = 1;
    push(8'hA5); wait_idle();
    read_rx();
    // R9 R7 R8: chained pair, sparse ticks, interrupt enabled, no read between
    tei_en = 1; tick_div = 3;
    push(8'h5A); push(8'hC3); wait_idle();
    cycles(10);
    tei_en = 0; cycles(3); tei_en = 1;
    read_rx();
    // R5: external clock mode
    tick_div = 2; ext_mode = 1; ext_half = 5;
    push(8'h81); push(8'h7E); wait_idle();
    read_rx();
    ext_half = 0; cycles(10); ext_mode = 0;
    // R7: read coinciding with delivery, then extremes
    tick_div = 1;
    push(8'hFF); wait_idle();
    push(8'h00);
    while (!(m_busy && m_got == 7 && m_want_cap)) @(negedge clk);
    rx_read = 1; @(negedge clk); rx_read = 0;
    wait_idle();
    tx_en = 0; push_off();
    cycles(20);
    checking = 0;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    end
    $finish;
  end

  // R10: valid held with enable low while ticks run
  task automatic push_off();
    @(negedge clk); tx_byte = 8'h96; tx_valid = 1;
    cycles(30);
    tx_valid = 0;
  endtask
endmodule